// File: doc/BRIEF.md
# Transaction-Counting Phase Barrier

This block is a reusable split barrier in hardware. Requesters register arrivals through a command port. They may also say how many bytes of data must land before the current phase may close. A DMA engine reports each finished transfer on a separate report port. A phase closes only when the arrival tally has reached the target loaded at init and no expected bytes remain outstanding. At that point a single phase bit flips and both counters clear, so the same barrier serves the next round without being initialised again.

Two ways of observing completion are offered. The poll port is combinational: it compares a requested parity against the live phase bit and answers at once. The wait port runs a small state machine with three states. `WS_IDLE` accepts a request. `WS_SUSPEND` holds the requester while a cycle counter runs. `WS_REPLY` presents a one-cycle answer. The transitions are named as follows:
- **accept-hit** (IDLE→REPLY): the phase has already passed.
- **accept-park** (IDLE→SUSPEND): the phase is still pending.
- **wake** (SUSPEND→REPLY, answer 1): the phase completes.
- **expire** (SUSPEND→REPLY, answer 0): the limit is reached.
- **release** (REPLY→IDLE): the answer has been presented.

An answer of 0 means only that the time limit ran out.

Top module: `phase_barrier_unit`

## Requirements
- R1: After reset the phase bit is 0, no phase can complete until an init command arrives, and the wait port is idle.
- R2: Command opcode 1 (arrive) adds `cmd_arg` to the arrival tally. Any sequence of arrivals whose sum reaches the target loaded by opcode 0 (init) completes the phase, provided no bytes are awaited.
- R3: Opcode 2 (expect) adds `cmd_arg` bytes to the awaited count. The phase cannot complete while any of those bytes are unreported, even if all arrivals are in.
- R4: Once reports cover the expected bytes, the byte condition is met. Bytes reported beyond that are discarded when the phase completes and do not count toward the next phase.
- R5: Bytes reported before the matching expect command are held as a signed credit and offset the later expectation.
- R6: On completion the phase bit toggles and the tally and awaited bytes return to zero. The arrival target stays as loaded, and init resets phase, tally and bytes to 0.
- R7: Opcode 3 registers `cmd_arg` bytes and one arrival as one operation. The phase cannot close on that arrival before those bytes are reported.
- R8: A command and a byte report in the same cycle are both applied before completion is judged.
- R9: `poll_done` is 1 exactly when `poll_parity` differs from the current phase bit. It reflects a completion in the cycle after the completing clock edge.
- R10: A wait on a parity that has already completed answers `resp_done`=1 one cycle after the request. A wait that is pending when the phase completes answers 1 shortly after the completion.
- R11: A wait whose phase does not complete answers `resp_done`=0 exactly `wait_limit`+1 cycles after the request. A `wait_limit` of 0 selects 64.
- R12: A wait request made while `wait_busy` is 1 is ignored and produces no answer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 init, 1 arrive, 2 expect, 3 expect-and-arrive |
| cmd_arg | input | ARG_W | Target, arrival count or byte count |
| xfer_valid | input | 1 | Transfer report strobe |
| xfer_bytes | input | XFER_W | Bytes completed by the DMA engine |
| poll_parity | input | 1 | Parity being polled |
| poll_done | output | 1 | Polled parity has completed |
| wait_req | input | 1 | Suspending wait request |
| wait_parity | input | 1 | Parity the wait is for |
| wait_limit | input | TO_W | Timeout in cycles, 0 selects the default |
| wait_busy | output | 1 | Wait engine occupied |
| resp_valid | output | 1 | One-cycle wait answer strobe |
| resp_done | output | 1 | 1 phase completed, 0 timeout |
| phase_out | output | 1 | Current phase bit |

## Verification
A command or report sampled at one clock edge changes `phase_out` and `poll_done` right after that edge. The bench therefore drives on the falling edge and checks on the next falling edge. A wait answer appears one cycle after the request when the phase has already passed, and `wait_limit`+1 cycles after the request on timeout. The scoreboard stamps each request with a rising-edge count and compares the answer's stamp against that latency. For wakes, whose exact cycle depends on when the phase closes, the latency is left unchecked and only the answer value is compared. Any answer without a queued expectation, such as one caused by a request that should have been ignored, is a failure.

// File: rtl/pbu_pkg.sv
package pbu_pkg;
    typedef enum logic [1:0] {
        OP_INIT    = 2'd0,
        OP_ARRIVE  = 2'd1,
        OP_EXPECT  = 2'd2,
        OP_EXP_ARR = 2'd3
    } pbu_op_e;

    typedef enum logic [1:0] {
        WS_IDLE    = 2'd0,
        WS_SUSPEND = 2'd1,
        WS_REPLY   = 2'd2
    } pbu_wstate_e;
endpackage

// File: rtl/pbu_tally.sv
module pbu_tally #(
    parameter int ARG_W  = 16,
    parameter int XFER_W = 16,
    parameter int BYTE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              xfer_valid,
    input  logic [XFER_W-1:0] xfer_bytes,
    output logic              phase_q
);
    import pbu_pkg::*;

    localparam int SUM_W = ARG_W + 1;

    pbu_op_e                  op;
    logic [ARG_W-1:0]         target_q;
    logic [ARG_W-1:0]         tally_q;
    logic signed [BYTE_W-1:0] pend_q;
    logic [ARG_W-1:0]         arr_add;
    logic [ARG_W-1:0]         exp_add;
    logic                     is_init;
    logic [SUM_W-1:0]         tally_sum;
    logic [BYTE_W-1:0]        exp_ext;
    logic [BYTE_W-1:0]        xfer_ext;
    logic signed [BYTE_W-1:0] pend_sum;
    logic                     fire;

    assign op = pbu_op_e'(cmd_op);

    always_comb begin
        arr_add = '0;
        exp_add = '0;
        is_init = 1'b0;
        if (cmd_valid) begin
            unique case (op)
                OP_INIT:    is_init = 1'b1;
                OP_ARRIVE:  arr_add = cmd_arg;
                OP_EXPECT:  exp_add = cmd_arg;
                OP_EXP_ARR: begin
                    exp_add = cmd_arg;
                    arr_add = ARG_W'(1);
                end
                default:    is_init = 1'b0;
            endcase
        end
    end

    always_comb begin
        exp_ext   = BYTE_W'(exp_add);
        xfer_ext  = xfer_valid ? BYTE_W'(xfer_bytes) : '0;
        tally_sum = SUM_W'(tally_q) + SUM_W'(arr_add);
        pend_sum  = pend_q + $signed(exp_ext) - $signed(xfer_ext);
        fire      = !is_init && (target_q != '0)
                    && (tally_sum >= SUM_W'(target_q))
                    && (pend_sum <= 0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            tally_q  <= '0;
            pend_q   <= '0;
            phase_q  <= 1'b0;
        end else if (is_init) begin
            target_q <= cmd_arg;
            tally_q  <= '0;
            pend_q   <= '0;
            phase_q  <= 1'b0;
        end else if (fire) begin
            tally_q  <= '0;
            pend_q   <= '0;
            phase_q  <= ~phase_q;
        end else begin
            tally_q  <= tally_sum[ARG_W-1:0];
            pend_q   <= pend_sum;
        end
    end

    // R6
    toggle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> (tally_q == '0 && pend_q == '0));

    // R6
    target_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(is_init) |-> (target_q == $past(target_q)));

    // R3
    bytes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_q) > 0 && !$past(xfer_valid) && !$past(is_init))
            |-> (phase_q == $past(phase_q)));
endmodule

// File: rtl/pbu_waiter.sv
module pbu_waiter #(
    parameter int TO_W        = 16,
    parameter int DEF_TIMEOUT = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            phase,
    input  logic            wait_req,
    input  logic            wait_parity,
    input  logic [TO_W-1:0] wait_limit,
    output logic            wait_busy,
    output logic            resp_valid,
    output logic            resp_done
);
    import pbu_pkg::*;

    localparam logic [TO_W-1:0] DEF_LIM = TO_W'(DEF_TIMEOUT);

    pbu_wstate_e     state_q, state_n;
    logic            parity_q, parity_n;
    logic [TO_W-1:0] lim_q, lim_n;
    logic [TO_W-1:0] cnt_q, cnt_n;
    logic            done_q, done_n;

    always_comb begin
        state_n  = state_q;
        parity_n = parity_q;
        lim_n    = lim_q;
        cnt_n    = cnt_q;
        done_n   = done_q;
        unique case (state_q)
            WS_IDLE: begin
                if (wait_req) begin
                    parity_n = wait_parity;
                    cnt_n    = '0;
                    lim_n    = (wait_limit == '0) ? DEF_LIM : wait_limit;
                    if (wait_parity != phase) begin
                        state_n = WS_REPLY;
                        done_n  = 1'b1;
                    end else begin
                        state_n = WS_SUSPEND;
                    end
                end
            end
            WS_SUSPEND: begin
                if (parity_q != phase) begin
                    state_n = WS_REPLY;
                    done_n  = 1'b1;
                end else if (cnt_q == lim_q - 1'b1) begin
                    state_n = WS_REPLY;
                    done_n  = 1'b0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            WS_REPLY: state_n = WS_IDLE;
            default:  state_n = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= WS_IDLE;
            parity_q <= 1'b0;
            lim_q    <= DEF_LIM;
            cnt_q    <= '0;
            done_q   <= 1'b0;
        end else begin
            state_q  <= state_n;
            parity_q <= parity_n;
            lim_q    <= lim_n;
            cnt_q    <= cnt_n;
            done_q   <= done_n;
        end
    end

    always_comb begin
        wait_busy  = (state_q != WS_IDLE);
        resp_valid = (state_q == WS_REPLY);
        resp_done  = done_q;
    end

    // R11
    suspend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_SUSPEND) |-> (cnt_q < lim_q));

    // R10
    reply_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R12
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_SUSPEND && wait_req) |=> (parity_q == $past(parity_q)));
endmodule

// File: rtl/phase_barrier_unit.sv
module phase_barrier_unit #(
    parameter int ARG_W       = 16,
    parameter int XFER_W      = 16,
    parameter int BYTE_W      = 20,
    parameter int TO_W        = 16,
    parameter int DEF_TIMEOUT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              xfer_valid,
    input  logic [XFER_W-1:0] xfer_bytes,
    input  logic              poll_parity,
    output logic              poll_done,
    input  logic              wait_req,
    input  logic              wait_parity,
    input  logic [TO_W-1:0]   wait_limit,
    output logic              wait_busy,
    output logic              resp_valid,
    output logic              resp_done,
    output logic              phase_out
);
    logic phase;

    pbu_tally #(.ARG_W(ARG_W), .XFER_W(XFER_W), .BYTE_W(BYTE_W)) u_tally (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_arg    (cmd_arg),
        .xfer_valid (xfer_valid),
        .xfer_bytes (xfer_bytes),
        .phase_q    (phase)
    );

    pbu_waiter #(.TO_W(TO_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_waiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .wait_req    (wait_req),
        .wait_parity (wait_parity),
        .wait_limit  (wait_limit),
        .wait_busy   (wait_busy),
        .resp_valid  (resp_valid),
        .resp_done   (resp_done)
    );

    assign poll_done = (poll_parity != phase);
    assign phase_out = phase;
endmodule

// File: tb/phase_barrier_unit_tb.sv
`timescale 1ns/1ps
module phase_barrier_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_arg = '0;
    logic        xfer_valid = 1'b0;
    logic [15:0] xfer_bytes = '0;
    logic        poll_parity = 1'b0;
    logic        poll_done;
    logic        wait_req = 1'b0;
    logic        wait_parity = 1'b0;
    logic [15:0] wait_limit = '0;
    logic        wait_busy, resp_valid, resp_done, phase_out;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    typedef struct {
        bit    done;
        int    lat;
        int    issued;
        string req;
    } exp_t;
    exp_t sb[$];

    phase_barrier_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes),
        .poll_parity(poll_parity), .poll_done(poll_done),
        .wait_req(wait_req), .wait_parity(wait_parity), .wait_limit(wait_limit),
        .wait_busy(wait_busy), .resp_valid(resp_valid), .resp_done(resp_done),
        .phase_out(phase_out)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // monitor: pops one expectation per answer
    always @(negedge clk) begin
        if (rst_n && resp_valid) begin
            if (sb.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R12: actual unexpected answer %0d expected none", resp_done);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(e.req, int'(resp_done), int'(e.done));
                if (e.lat >= 0) chk(e.req, cyc - e.issued, e.lat);
            end
        end
    end

    task automatic cmdx(input logic v, input logic [1:0] op, input int arg,
                        input logic xv, input int xb);
        cmd_valid  = v;
        cmd_op     = op;
        cmd_arg    = 16'(arg);
        xfer_valid = xv;
        xfer_bytes = 16'(xb);
        @(negedge clk);
        cmd_valid  = 1'b0;
        xfer_valid = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] op, input int arg);
        cmdx(1'b1, op, arg, 1'b0, 0);
    endtask

    task automatic rep(input int b);
        cmdx(1'b0, 2'd0, 0, 1'b1, b);
    endtask

    task automatic wreq(input logic par, input int lim, input bit push,
                        input bit done, input int lat, input string req);
        wait_req    = 1'b1;
        wait_parity = par;
        wait_limit  = 16'(lim);
        if (push) begin
            exp_t e;
            e.done = done; e.lat = lat; e.issued = cyc; e.req = req;
            sb.push_back(e);
        end
        @(negedge clk);
        wait_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (wait_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", phase_out, 0);
        chk("R1", wait_busy, 0);
        poll_parity = 1'b0; #0.1; chk("R1", poll_done, 0);
        poll_parity = 1'b1; #0.1; chk("R1", poll_done, 1);
        cmd(2'd1, 9);
        chk("R1", phase_out, 0);

        // R2 arrivals accumulate to target 4
        cmd(2'd0, 4);
        chk("R2", phase_out, 0);
        cmd(2'd1, 1);
        chk("R2", phase_out, 0);
        cmd(2'd1, 3);
        chk("R2", phase_out, 1);

        // R6 target kept for next phase
        cmd(2'd1, 2);
        chk("R6", phase_out, 1);
        cmd(2'd1, 2);
        chk("R6", phase_out, 0);

        // R3 bytes hold completion
        cmd(2'd2, 100);
        cmd(2'd1, 4);
        chk("R3", phase_out, 0);
        rep(60);
        chk("R3", phase_out, 0);
        rep(40);
        chk("R3", phase_out, 1);

        // R4 over-report completes, excess discarded
        cmd(2'd2, 50);
        cmd(2'd1, 4);
        chk("R4", phase_out, 1);
        rep(80);
        chk("R4", phase_out, 0);
        cmd(2'd2, 30);
        cmd(2'd1, 4);
        chk("R4", phase_out, 0);
        rep(30);
        chk("R4", phase_out, 1);

        // R5 early report credit
        rep(30);
        chk("R5", phase_out, 1);
        cmd(2'd2, 30);
        cmd(2'd1, 4);
        chk("R5", phase_out, 0);

        // R7 combined expect-and-arrive
        cmd(2'd0, 1);
        cmd(2'd3, 16);
        chk("R7", phase_out, 0);
        rep(16);
        chk("R7", phase_out, 1);
        // R9 poll follows phase
        poll_parity = 1'b0; #0.1; chk("R9", poll_done, 1);
        poll_parity = 1'b1; #0.1; chk("R9", poll_done, 0);

        // R8 same-cycle command and report
        cmd(2'd0, 2);
        chk("R6", phase_out, 0);
        cmd(2'd2, 8);
        cmdx(1'b1, 2'd1, 2, 1'b1, 8);
        chk("R8", phase_out, 1);

        // R10 already-complete parity answers in one cycle
        wreq(1'b0, 10, 1'b1, 1'b1, 1, "R10");
        wait_idle();

        // R11 timeout with explicit limit; R12 request while busy ignored
        wreq(1'b1, 10, 1'b1, 1'b0, 11, "R11");
        chk("R12", wait_busy, 1);
        wreq(1'b0, 5, 1'b0, 1'b0, 0, "R12");
        wait_idle();

        // R11 default limit
        wreq(1'b1, 0, 1'b1, 1'b0, 65, "R11");
        wait_idle();

        // R10 wake on completion
        wreq(1'b1, 200, 1'b1, 1'b1, -1, "R10");
        repeat (5) @(negedge clk);
        cmd(2'd1, 2);
        chk("R10", phase_out, 0);
        wait_idle();

        chk("R12", sb.size(), 0);
        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(5ns * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule